// File: doc/BRIEF.md
# Segment Memory Protection Unit

This block decides whether a memory access may proceed. Software describes memory as a foreground table of segments, each holding a start address, an attribute word and an enable bit. A segment covers every address from its own start up to the start of the next segment, and the last segment extends to the top of the address space. For each access request the block reads the address, the access kind and the privilege ring. One cycle later it returns the read/write/execute rights, a cache-behaviour code and a fault cause. Addresses pass through untranslated.

An address may match no enabled foreground segment, or it may match a segment whose enable bit is clear. In either case the attribute comes from a fixed background table that is built into the block. Software can also program a single segment, load the whole enable register at once, read a segment back, and probe an address to learn which segment and which attribute would apply.

Top module: `seg_prot_unit`

## Requirements
- R1: Foreground segment i matches address A when A >= start[i] and either i is the last segment or A < start[i+1]. The lookup covers all segments in parallel, and `rsp_valid` is high exactly in the cycle after `req_valid`, with the result registered.
- R2: If two or more foreground segments match, the response has `rsp_allow`=0, `rsp_rights`=0 and `rsp_cache`=0. The cause is 1 for load/store kinds and 2 for fetch.
- R3: The foreground attribute applies only when exactly one segment matches and that segment's enable bit is 1. Otherwise the matching background segment's attribute applies.
- R4: The background table has NUM_BG equal slices. Slice k starts at k*2^32/NUM_BG, so the first slice starts at 0. Even slices carry attribute 0x00180F00 and odd slices carry attribute 0x00000B00.
- R5: The rights index is attribute bits [11:8], and `rsp_rights` is {R,W,X}. Ring 0 uses this table: 4:R, 5:RX, 6:RW, 7:RWX, 8:W, 9:RW, 10:RW, 11:RWX, 12:R, 13:RX, 14:RW, 15:RWX, all others none. Rings 1 to 3 use this table: 8:W, 9:RWX, 10:R, 11:RX, 12:R, 13:RX, 14:RW, 15:RWX, all others none. `req_kind` 0 (load) needs R, 1 (store) needs W, and 2 or 3 (fetch) needs X. A missing right gives cause 3 for a load, 4 for a store or 5 for a fetch. A permitted access gives cause 0 and `rsp_allow`=1.
- R6: The memory type is mt = attribute bits [20:12]. The region is cached when mt[8:7]=11, when mt[8:7]=10 with mt[3]=0, or when (mt & 0x18F)=0x089. `rsp_cache` is 0 for an uncached region. For a cached region it is 2 (write-back) when mt[2]=1 and 1 (write-through) otherwise.
- R7: A segment write takes the segment number from `wr_attr_op[4:0]`. It stores `wr_addr_op` rounded down to 2^ALIGN_LOG2, stores `wr_attr_op & 0x001FFF00`, and loads `wr_addr_op[0]` into that segment's enable bit.
- R8: An enable-register write loads `en_wr_data[NUM_SEG-1:0]` and drops the higher bits. When a segment write happens in the same cycle, the segment write's enable bit takes precedence for that segment.
- R9: A read of segment n returns `rd_start` = start | enable bit and `rd_attr` = the stored attribute, one cycle after `rd_valid`. A read of n >= NUM_SEG returns zero in both. A write to n >= NUM_SEG changes nothing.
- R10: A probe of address A sets `probe_done` one cycle later. When the foreground applies, `probe_result` = attribute | segment number | bit 31. When a single match is disabled, it is the background attribute | segment number. When there is no match, it is the background attribute | bit 30. When there are several matches, it is the background attribute | bit 30 with `probe_multi`=1.
- R11: Synchronous active-low reset clears every start, attribute and enable bit, and clears `rsp_valid`, `probe_done`, `rd_start` and `rd_attr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access check strobe |
| req_addr | input | 32 | Access address |
| req_kind | input | 2 | 0 load, 1 store, 2/3 fetch |
| req_ring | input | 2 | Privilege ring, 0 most privileged |
| rsp_valid | output | 1 | Result valid |
| rsp_allow | output | 1 | Access permitted |
| rsp_cause | output | 3 | Fault cause code |
| rsp_rights | output | 3 | {R,W,X} rights in the ring |
| rsp_cache | output | 2 | 0 bypass, 1 write-through, 2 write-back |
| wr_valid | input | 1 | Segment write strobe |
| wr_addr_op | input | 32 | Start address, bit 0 is the enable bit |
| wr_attr_op | input | 32 | Attribute, bits [4:0] are the segment number |
| en_wr_valid | input | 1 | Enable register write strobe |
| en_wr_data | input | 32 | New enable bits |
| rd_valid | input | 1 | Segment read strobe |
| rd_idx | input | 5 | Segment number to read |
| rd_start | output | 32 | Start address OR enable bit |
| rd_attr | output | 32 | Stored attribute |
| probe_valid | input | 1 | Probe strobe |
| probe_addr | input | 32 | Address to probe |
| probe_done | output | 1 | Probe result valid |
| probe_multi | output | 1 | Probe found several matches |
| probe_result | output | 32 | Probe report word |

## Verification
The multi-match case is the hardest to reach, because with correctly sorted start addresses no address can fall in two segments. The bench reaches it by deliberately reprogramming one segment's start below its predecessor's start. Two ranges then overlap, and both the access and the probe paths see two matches. The bench also covers a disabled single match, to tell foreground results from background ones. That test uses attributes whose cache codes differ between the two tables, so the output shows which table supplied the result.

// File: rtl/seg_prot_pkg.sv
// Shared types and decode functions for the segment protection unit.
// Assumes attribute layout: rights index [11:8], memory type [20:12].
package seg_prot_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE        = 3'd0,
        CAUSE_MULTI_DATA  = 3'd1,
        CAUSE_MULTI_FETCH = 3'd2,
        CAUSE_LOAD_DENY   = 3'd3,
        CAUSE_STORE_DENY  = 3'd4,
        CAUSE_FETCH_DENY  = 3'd5
    } fault_e;

    localparam logic [31:0] ATTR_KEEP = 32'h001F_FF00;

    // Rights {R,W,X} for a rights index; user = any ring other than 0.
    function automatic logic [2:0] rights_of(input logic [3:0] idx, input logic user);
        logic [2:0] r;
        r = 3'b000;
        if (!user) begin
            case (idx)
                4'd4, 4'd12:         r = 3'b100;
                4'd5, 4'd13:         r = 3'b101;
                4'd6, 4'd9, 4'd10,
                4'd14:               r = 3'b110;
                4'd7, 4'd11, 4'd15:  r = 3'b111;
                4'd8:                r = 3'b010;
                default:             r = 3'b000;
            endcase
        end else begin
            case (idx)
                4'd8:                r = 3'b010;
                4'd9, 4'd15:         r = 3'b111;
                4'd10, 4'd12:        r = 3'b100;
                4'd11, 4'd13:        r = 3'b101;
                4'd14:               r = 3'b110;
                default:             r = 3'b000;
            endcase
        end
        return r;
    endfunction

    // Cache code from memory type: 0 bypass, 1 write-through, 2 write-back.
    function automatic logic [1:0] cache_of(input logic [8:0] mt);
        logic cached;
        cached = (mt[8:7] == 2'b11) || (mt[8:7] == 2'b10 && !mt[3]) ||
                 ((mt & 9'h18F) == 9'h089);
        if (!cached)
            return 2'd0;
        return mt[2] ? 2'd2 : 2'd1;
    endfunction

    // Fixed background attribute for slice k.
    function automatic logic [31:0] bg_attr(input int k);
        return (k % 2 == 0) ? 32'h0018_0F00 : 32'h0000_0B00;
    endfunction

endpackage

// File: rtl/seg_prot_regs.sv
// Segment table storage: starts, attributes, enable bits and the read port.
// Assumes NUM_SEG is 2..32 so a segment number fits in five bits.
module seg_prot_regs #(
    parameter int NUM_SEG    = 8,
    parameter int ALIGN_LOG2 = 12,
    localparam int IW        = $clog2(NUM_SEG)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_valid,
    input  logic [31:0]               wr_addr_op,
    input  logic [31:0]               wr_attr_op,
    input  logic                      en_wr_valid,
    input  logic [31:0]               en_wr_data,
    input  logic                      rd_valid,
    input  logic [4:0]                rd_idx,
    output logic [NUM_SEG-1:0][31:0]  starts,
    output logic [NUM_SEG-1:0][31:0]  attrs,
    output logic [NUM_SEG-1:0]        en_q,
    output logic [31:0]               rd_start,
    output logic [31:0]               rd_attr
);
    localparam logic [31:0] ALIGN_MASK = ~((32'd1 << ALIGN_LOG2) - 32'd1);

    logic [4:0]    wr_num;
    logic          wr_hit;
    logic          rd_hit;
    logic [IW-1:0] wr_sel;
    logic [IW-1:0] rd_sel;

    // Decode the segment numbers and their range checks.
    always_comb begin
        wr_num = wr_attr_op[4:0];
        wr_hit = wr_valid && (32'(wr_num) < NUM_SEG);
        rd_hit = 32'(rd_idx) < NUM_SEG;
        wr_sel = wr_num[IW-1:0];
        rd_sel = rd_idx[IW-1:0];
    end

    // Start and attribute storage, written one segment at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            starts <= '0;
            attrs  <= '0;
        end else if (wr_hit) begin
            starts[wr_sel] <= wr_addr_op & ALIGN_MASK;
            attrs[wr_sel]  <= wr_attr_op & seg_prot_pkg::ATTR_KEEP;
        end
    end

    // Enable register: bulk load first, the segment write's bit overrides it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            if (en_wr_valid)
                en_q <= en_wr_data[NUM_SEG-1:0];
            if (wr_hit)
                en_q[wr_sel] <= wr_addr_op[0];
        end
    end

    // Registered read port, zero for numbers beyond the table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_start <= '0;
            rd_attr  <= '0;
        end else if (rd_valid) begin
            rd_start <= rd_hit ? (starts[rd_sel] | {31'd0, en_q[rd_sel]}) : 32'd0;
            rd_attr  <= rd_hit ? attrs[rd_sel] : 32'd0;
        end
    end
endmodule

// File: rtl/seg_prot_match.sv
// Parallel range matcher over a sorted list of segment starts.
// Reports no match, several matches, and the highest matching index.
module seg_prot_match #(
    parameter int N = 8,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0][31:0] starts,
    input  logic [31:0]        addr,
    output logic               hit_none,
    output logic               hit_multi,
    output logic [IW-1:0]      hit_idx
);
    logic [N-1:0] hit;

    // One comparator pair per segment; the last one is open-ended.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        if (i == N - 1) begin : g_last
            assign hit[i] = addr >= starts[i];
        end else begin : g_mid
            assign hit[i] = (addr >= starts[i]) && (addr < starts[i+1]);
        end
    end

    // Fold the hit vector into none / multi flags and the last hit index.
    always_comb begin
        logic seen;
        seen      = 1'b0;
        hit_multi = 1'b0;
        hit_idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                if (seen)
                    hit_multi = 1'b1;
                seen    = 1'b1;
                hit_idx = IW'(i);
            end
        end
        hit_none = !seen;
    end
endmodule

// File: rtl/seg_prot_unit.sv
// Top of the segment protection unit: table storage, foreground and
// background lookups for access checks and probes, registered results.
// Assumes NUM_BG is a power of two of at least 2 and software keeps
// starts sorted (unsorted starts surface as multi-match faults).
module seg_prot_unit #(
    parameter int NUM_SEG    = 8,
    parameter int NUM_BG     = 4,
    parameter int ALIGN_LOG2 = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [31:0] req_addr,
    input  logic [1:0]  req_kind,
    input  logic [1:0]  req_ring,
    output logic        rsp_valid,
    output logic        rsp_allow,
    output logic [2:0]  rsp_cause,
    output logic [2:0]  rsp_rights,
    output logic [1:0]  rsp_cache,
    input  logic        wr_valid,
    input  logic [31:0] wr_addr_op,
    input  logic [31:0] wr_attr_op,
    input  logic        en_wr_valid,
    input  logic [31:0] en_wr_data,
    input  logic        rd_valid,
    input  logic [4:0]  rd_idx,
    output logic [31:0] rd_start,
    output logic [31:0] rd_attr,
    input  logic        probe_valid,
    input  logic [31:0] probe_addr,
    output logic        probe_done,
    output logic        probe_multi,
    output logic [31:0] probe_result
);
    import seg_prot_pkg::*;

    localparam int FW = $clog2(NUM_SEG);
    localparam int BW = $clog2(NUM_BG);

    logic [NUM_SEG-1:0][31:0] starts;
    logic [NUM_SEG-1:0][31:0] attrs;
    logic [NUM_SEG-1:0]       en_q;
    logic [NUM_BG-1:0][31:0]  bg_starts;
    logic [NUM_BG-1:0][31:0]  bg_attrs;

    logic          a_none, a_multi, p_none, p_multi, ab_none_u, ab_multi_u, pb_none_u, pb_multi_u;
    logic [FW-1:0] a_idx, p_idx;
    logic [BW-1:0] ab_idx, pb_idx;

    // Background slices: equal power-of-two partitions of the address space.
    for (genvar k = 0; k < NUM_BG; k++) begin : g_bg
        assign bg_starts[k] = 32'(k) << (32 - BW);
        assign bg_attrs[k]  = bg_attr(k);
    end

    seg_prot_regs #(.NUM_SEG(NUM_SEG), .ALIGN_LOG2(ALIGN_LOG2)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr_op(wr_addr_op), .wr_attr_op(wr_attr_op),
        .en_wr_valid(en_wr_valid), .en_wr_data(en_wr_data),
        .rd_valid(rd_valid), .rd_idx(rd_idx),
        .starts(starts), .attrs(attrs), .en_q(en_q),
        .rd_start(rd_start), .rd_attr(rd_attr)
    );

    seg_prot_match #(.N(NUM_SEG)) fg_acc_i (
        .starts(starts), .addr(req_addr),
        .hit_none(a_none), .hit_multi(a_multi), .hit_idx(a_idx));
    seg_prot_match #(.N(NUM_BG)) bg_acc_i (
        .starts(bg_starts), .addr(req_addr),
        .hit_none(ab_none_u), .hit_multi(ab_multi_u), .hit_idx(ab_idx));
    seg_prot_match #(.N(NUM_SEG)) fg_prb_i (
        .starts(starts), .addr(probe_addr),
        .hit_none(p_none), .hit_multi(p_multi), .hit_idx(p_idx));
    seg_prot_match #(.N(NUM_BG)) bg_prb_i (
        .starts(bg_starts), .addr(probe_addr),
        .hit_none(pb_none_u), .hit_multi(pb_multi_u), .hit_idx(pb_idx));

    logic        a_fg_use;
    logic [31:0] a_attr;
    logic [2:0]  a_rights;
    logic        a_ok;
    fault_e      a_cause;

    // Access path: pick the attribute, decode rights and the fault cause.
    always_comb begin
        a_fg_use = !a_none && !a_multi && en_q[a_idx];
        a_attr   = a_fg_use ? attrs[a_idx] : bg_attrs[ab_idx];
        a_rights = rights_of(a_attr[11:8], req_ring != 2'd0);
        case (req_kind)
            2'd0:    a_ok = a_rights[2];
            2'd1:    a_ok = a_rights[1];
            default: a_ok = a_rights[0];
        endcase
        if (a_multi)
            a_cause = req_kind[1] ? CAUSE_MULTI_FETCH : CAUSE_MULTI_DATA;
        else if (!a_ok)
            a_cause = (req_kind == 2'd0) ? CAUSE_LOAD_DENY :
                      (req_kind == 2'd1) ? CAUSE_STORE_DENY : CAUSE_FETCH_DENY;
        else
            a_cause = CAUSE_NONE;
    end

    // Registered access response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_allow  <= 1'b0;
            rsp_cause  <= 3'd0;
            rsp_rights <= 3'd0;
            rsp_cache  <= 2'd0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_allow  <= (a_cause == CAUSE_NONE);
                rsp_cause  <= a_cause;
                rsp_rights <= a_multi ? 3'd0 : a_rights;
                rsp_cache  <= a_multi ? 2'd0 : cache_of(a_attr[20:12]);
            end
        end
    end

    logic        p_fg_use;
    logic [31:0] p_word;

    // Probe path: build the report word.
    always_comb begin
        p_fg_use = !p_none && !p_multi && en_q[p_idx];
        if (p_fg_use)
            p_word = attrs[p_idx] | 32'(p_idx) | 32'h8000_0000;
        else if (p_none || p_multi)
            p_word = bg_attrs[pb_idx] | 32'h4000_0000;
        else
            p_word = bg_attrs[pb_idx] | 32'(p_idx);
    end

    // Registered probe response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            probe_done   <= 1'b0;
            probe_multi  <= 1'b0;
            probe_result <= 32'd0;
        end else begin
            probe_done <= probe_valid;
            if (probe_valid) begin
                probe_multi  <= p_multi;
                probe_result <= p_word;
            end
        end
    end
endmodule

// File: rtl/seg_prot_checker.sv
// Property checker for the segment protection unit, bound to the top.
// Assumes it sees the top's ports and its enable register.
module seg_prot_checker #(
    parameter int NUM_SEG = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               rsp_valid,
    input logic               rsp_allow,
    input logic [2:0]         rsp_cause,
    input logic [2:0]         rsp_rights,
    input logic               wr_valid,
    input logic [31:0]        wr_attr_op,
    input logic               en_wr_valid,
    input logic [31:0]        en_wr_data,
    input logic [NUM_SEG-1:0] en_q,
    input logic               probe_valid,
    input logic               probe_done,
    input logic               probe_multi,
    input logic [31:0]        probe_result
);
    assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_rsp_has_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    assert_multi_denies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_cause == 3'd1 || rsp_cause == 3'd2)) |-> (!rsp_allow && rsp_rights == 3'd0));

    assert_allow_clean_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_allow) |-> rsp_cause == 3'd0);

    assert_enable_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_wr_valid && !wr_valid) |=> en_q == $past(en_wr_data[NUM_SEG-1:0]));

    assert_oob_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !en_wr_valid && 32'(wr_attr_op[4:0]) >= NUM_SEG) |=> $stable(en_q));

    assert_probe_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        probe_done |-> $past(probe_valid));

    assert_probe_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (probe_done && probe_result[31]) |-> (!probe_multi && !probe_result[30]));
endmodule

bind seg_prot_unit seg_prot_checker #(.NUM_SEG(NUM_SEG)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
    .rsp_allow(rsp_allow), .rsp_cause(rsp_cause), .rsp_rights(rsp_rights),
    .wr_valid(wr_valid), .wr_attr_op(wr_attr_op), .en_wr_valid(en_wr_valid),
    .en_wr_data(en_wr_data), .en_q(en_q), .probe_valid(probe_valid),
    .probe_done(probe_done), .probe_multi(probe_multi), .probe_result(probe_result)
);

// File: tb/seg_prot_unit_tb_top.sv
// Directed bench for the segment protection unit: one task per scenario.
module seg_prot_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_ring = '0;
    logic        rsp_valid, rsp_allow;
    logic [2:0]  rsp_cause, rsp_rights;
    logic [1:0]  rsp_cache;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_addr_op = '0, wr_attr_op = '0;
    logic        en_wr_valid = 1'b0;
    logic [31:0] en_wr_data = '0;
    logic        rd_valid = 1'b0;
    logic [4:0]  rd_idx = '0;
    logic [31:0] rd_start, rd_attr;
    logic        probe_valid = 1'b0;
    logic [31:0] probe_addr = '0;
    logic        probe_done, probe_multi;
    logic [31:0] probe_result;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    seg_prot_unit dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic access(input logic [31:0] a, input logic [1:0] kind, input logic [1:0] ring);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_kind = kind; req_ring = ring;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Expect {valid, allow, cause, rights, cache}.
    task automatic expect_rsp(input string req, input logic allow, input logic [2:0] cause,
                              input logic [2:0] rights, input logic [1:0] cache);
        chk(req, {28'd0, rsp_valid, rsp_allow, rsp_cause}, {28'd0, 1'b1, allow, cause});
        chk(req, {27'd0, rsp_rights, rsp_cache}, {27'd0, rights, cache});
    endtask

    task automatic wr_seg(input logic [31:0] a, input logic [31:0] at);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr_op = a; wr_attr_op = at;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic rd_seg(input logic [4:0] n);
        @(negedge clk);
        rd_valid = 1'b1; rd_idx = n;
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic probe(input logic [31:0] a);
        @(negedge clk);
        probe_valid = 1'b1; probe_addr = a;
        @(negedge clk);
        probe_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R11 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R11 probe_done", {31'd0, probe_done}, 32'd0);
        rd_seg(5'd0);
        chk("R11 start", rd_start, 32'd0);
        chk("R11 attr", rd_attr, 32'd0);
    endtask

    task automatic t_background;
        access(32'h0000_1000, 2'd0, 2'd0);
        expect_rsp("R4 bg0 load", 1'b1, 3'd0, 3'b111, 2'd1);
        access(32'h5000_0000, 2'd2, 2'd1);
        expect_rsp("R5 bg1 fetch ring1", 1'b1, 3'd0, 3'b101, 2'd0);
        access(32'h5000_0000, 2'd1, 2'd1);
        expect_rsp("R5 bg1 store ring1", 1'b0, 3'd4, 3'b101, 2'd0);
        access(32'h5000_0000, 2'd1, 2'd0);
        expect_rsp("R5 bg1 store ring0", 1'b1, 3'd0, 3'b111, 2'd0);
    endtask

    task automatic t_program;
        wr_seg(32'h0000_1123, 32'hFFE0_0460);
        wr_seg(32'h0000_2123, 32'h0018_4901);
        for (int i = 2; i < 7; i++)
            wr_seg(32'h1000 * (i + 1) + 32'h122, 32'h0F00 | i);
        wr_seg(32'h0010_0000, 32'h0000_0F07);
        rd_seg(5'd0);
        chk("R7 start rounded", rd_start, 32'h0000_1001);
        chk("R7 attr masked", rd_attr, 32'h0000_0400);
        access(32'h0000_1800, 2'd0, 2'd0);
        expect_rsp("R3 fg seg0 load", 1'b1, 3'd0, 3'b100, 2'd0);
        access(32'h0000_1800, 2'd1, 2'd0);
        expect_rsp("R5 seg0 store", 1'b0, 3'd4, 3'b100, 2'd0);
        access(32'h0000_1800, 2'd0, 2'd1);
        expect_rsp("R5 seg0 load ring1", 1'b0, 3'd3, 3'b000, 2'd0);
        access(32'h0000_2010, 2'd2, 2'd1);
        expect_rsp("R6 seg1 write-back", 1'b1, 3'd0, 3'b111, 2'd2);
        access(32'h0000_3000, 2'd2, 2'd0);
        expect_rsp("R3 disabled seg2 falls back", 1'b1, 3'd0, 3'b111, 2'd1);
    endtask

    task automatic t_probe;
        probe(32'h0000_2010);
        chk("R10 fg probe", probe_result, 32'h8018_4901);
        chk("R10 done", {31'd0, probe_done}, 32'd1);
        probe(32'h0000_0800);
        chk("R10 no match probe", probe_result, 32'h4018_0F00);
        probe(32'h0000_3000);
        chk("R10 disabled probe", probe_result, 32'h0018_0F02);
        access(32'h0000_0800, 2'd1, 2'd1);
        expect_rsp("R1 below first start", 1'b1, 3'd0, 3'b111, 2'd1);
    endtask

    task automatic t_enable;
        @(negedge clk);
        en_wr_valid = 1'b1; en_wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        en_wr_valid = 1'b0;
        rd_seg(5'd7);
        chk("R8 enable seg7", rd_start, 32'h0010_0001);
        access(32'h0000_3000, 2'd2, 2'd1);
        expect_rsp("R3 enabled seg2", 1'b1, 3'd0, 3'b111, 2'd0);
        wr_seg(32'h0000_0000, 32'h0000_0F09);
        rd_seg(5'd1);
        chk("R9 oob write ignored", rd_start, 32'h0000_2001);
        rd_seg(5'd9);
        chk("R9 oob read start", rd_start, 32'd0);
        chk("R9 oob read attr", rd_attr, 32'd0);
        @(negedge clk);
        en_wr_valid = 1'b1; en_wr_data = 32'd0;
        wr_valid = 1'b1; wr_addr_op = 32'h0000_4001; wr_attr_op = 32'h0000_0F03;
        @(negedge clk);
        en_wr_valid = 1'b0; wr_valid = 1'b0;
        rd_seg(5'd3);
        chk("R8 seg write wins", rd_start, 32'h0000_4001);
        rd_seg(5'd4);
        chk("R8 others cleared", rd_start, 32'h0000_5000);
    endtask

    task automatic t_multi;
        wr_seg(32'h0000_1001, 32'h0000_0F02);
        access(32'h0000_1800, 2'd0, 2'd0);
        expect_rsp("R2 multi load", 1'b0, 3'd1, 3'b000, 2'd0);
        access(32'h0000_1800, 2'd3, 2'd0);
        expect_rsp("R2 multi fetch", 1'b0, 3'd2, 3'b000, 2'd0);
        probe(32'h0000_1800);
        chk("R10 probe multi flag", {31'd0, probe_multi}, 32'd1);
        chk("R10 probe multi word", probe_result, 32'h4018_0F00);
        access(32'h0000_2010, 2'd1, 2'd1);
        expect_rsp("R1 reordered seg2", 1'b1, 3'd0, 3'b111, 2'd0);
        access(32'hFFFF_F000, 2'd1, 2'd1);
        expect_rsp("R4 last seg disabled bg3", 1'b0, 3'd4, 3'b101, 2'd0);
        access(32'h0000_4000, 2'd1, 2'd1);
        expect_rsp("R1 boundary seg3", 1'b1, 3'd0, 3'b111, 2'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_background();
        t_program();
        t_probe();
        t_enable();
        t_multi();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule